// File: doc/BRIEF.md
# Closed-Loop PWM Voltage Trim Controller

This block holds one converter output at a programmable 10-bit target code. It takes 10-bit ADC samples of that output, smooths them with a four-sample moving average, and drives a 10-bit PWM pin. An external RC filter turns the PWM into the trim voltage. The block also drives the enable pin of the converter.

When it starts, the block does not know whether more duty raises or lowers the output. It finds out by moving the duty by a fixed probe step and comparing a settled average taken before the step with one taken after it. Once the polarity is known, every new average either moves the duty one code toward the target or, inside a ±1-code deadband, holds the duty and reports lock.

A precharge start is also available. The duty is forced to full scale and applied at a PWM period boundary before the converter is enabled, and regulation then works downward from there. Dropping the enable request returns the block to idle at once and keeps the learned polarity.

Top module: `closed_loop_trim`

## Requirements
- R1: Every comparison uses the mean of the four newest samples (sum of four, divided by four, truncated). No average is produced until four samples have arrived since the block last left idle. An average is presented one cycle after the sample that completes it.
- R2: The PWM counter runs through 1024 clock cycles per period. `trim_pwm` is high while the count is below the applied duty, so duty 0 is always low and duty 1023 is high for 1023 of 1024 cycles. A new duty is applied only at the last count of a period.
- R3: With `precharge_sel` low, a rising request sets the duty to 512, raises `conv_en` on the next clock edge, and starts the polarity probe. If a polarity has already been learned since reset, the probe is skipped and tracking starts directly.
- R4: With `precharge_sel` high, the duty goes to 1023 and `conv_en` stays low. `conv_en` rises one clock after the period boundary at which 1023 becomes the applied duty.
- R5: Probe sequence:
  - The block waits for five averages and records the fifth as the baseline.
  - It then moves the duty by +8, or by −8 when fewer than 8 codes of headroom remain, and takes the fifth following average.
  - A difference of 2 codes or more sets `trim_pol`: 1 when the reading moved the same way as the duty, 0 otherwise. A smaller difference counts as a failed attempt.
  - The fourth failed attempt raises `fault`.
- R6: While tracking, each new average moves the duty by exactly one code. The duty goes up when the reading is below the target and `trim_pol` is 1, or when the reading is above the target and `trim_pol` is 0; otherwise it goes down. Between averages the duty does not change.
- R7: An average within ±1 code of `target` sets `locked` and leaves the duty unchanged. An average outside that band clears `locked` and resumes stepping.
- R8: When a step would move the duty past 0 or 1023, the duty stays where it is and `fault` rises. In fault, the duty stays frozen until the request drops.
- R9: One cycle after `en_req` is seen low, `conv_en`, `locked` and `fault` are low and the commanded duty is 0. The averager is emptied and `trim_pol` keeps its value.
- R10: Synchronous active-high reset clears every output, the learned polarity and the applied duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one PWM count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Request to run the converter and regulate |
| target | input | 10 | Desired averaged ADC code |
| sample_valid | input | 1 | One-cycle strobe marking a new ADC result |
| sample_data | input | 10 | ADC result of the converter output |
| precharge_sel | input | 1 | Start from full-scale duty before enabling |
| trim_pwm | output | 1 | PWM trim pin |
| conv_en | output | 1 | Converter enable |
| trim_pol | output | 1 | Learned polarity, 1 = more duty raises output |
| locked | output | 1 | Last average within the deadband |
| fault | output | 1 | Probe found no response, or the duty hit a limit |

## Verification
The properties assume that `target` and `precharge_sel` are changed only while `en_req` is low, and that `sample_valid` is a single-cycle pulse with idle cycles between pulses. The stimulus follows these rules. Samples arrive every eighth cycle. Each sample is taken from a plant model of the converter, driven by the duty that the reference model expects the block to command. Targets and modes change only between runs or while the request is low. The plants are chosen so that each run ends in a known state: a rising transfer, a falling transfer with a precharge start, an unreachable target, and a flat output that never responds to the probe.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRECHG,
        S_LAUNCH,
        S_PBASE,
        S_PWAIT,
        S_TRACK,
        S_FAULT
    } ctrl_state_e;

    // Polarity is positive when the reading moved the same way as the duty.
    function automatic logic probe_polarity(input logic reading_rose, input logic duty_rose);
        return reading_rose == duty_rose;
    endfunction

endpackage

// File: rtl/trim_avg.sv
module trim_avg #(
    parameter int AW   = 10,
    parameter int NAVG = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          smp_v,
    input  logic [AW-1:0] smp_d,
    output logic          avg_v,
    output logic [AW-1:0] avg_d
);
    localparam int FW = $clog2(NAVG);
    localparam int SW = AW + FW;
    localparam logic [FW-1:0] FULL = FW'(NAVG - 1);

    logic [AW-1:0] win_q [NAVG-1];
    logic [FW-1:0] fill_q;
    logic [SW-1:0] sum_c;

    // Window of the previous NAVG-1 samples, newest first.
    for (genvar g = 0; g < NAVG - 1; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[g] <= '0;
            end else if (smp_v) begin
                if (g == 0) win_q[g] <= smp_d;
                else        win_q[g] <= win_q[g-1];
            end
        end
    end

    always_comb begin
        sum_c = SW'(smp_d);
        for (int i = 0; i < NAVG - 1; i++) begin
            sum_c = sum_c + SW'(win_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            avg_v  <= 1'b0;
            avg_d  <= '0;
        end else if (clr) begin
            fill_q <= '0;
            avg_v  <= 1'b0;
        end else if (smp_v) begin
            if (fill_q != FULL) fill_q <= fill_q + FW'(1);
            avg_v <= (fill_q == FULL);
            avg_d <= sum_c[SW-1:FW];
        end else begin
            avg_v <= 1'b0;
        end
    end

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> !avg_v);
    assert_avg_follows_sample_R1: assert property (@(posedge clk) disable iff (rst)
        avg_v |-> $past(smp_v));

endmodule

// File: rtl/trim_pwm.sv
module trim_pwm #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] duty_i,
    output logic          pwm_o,
    output logic          bound_o
);
    localparam logic [DW-1:0] CMAX = '1;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] app_q;

    assign bound_o = (cnt_q == CMAX);
    assign pwm_o   = (cnt_q < app_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            app_q <= '0;
        end else begin
            cnt_q <= cnt_q + DW'(1);
            if (bound_o) app_q <= duty_i;
        end
    end

    assert_duty_only_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        !bound_o |=> $stable(app_q));
    assert_period_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        bound_o |=> (cnt_q == '0));

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
    import trim_pkg::*;
#(
    parameter int DW          = 10,
    parameter int AW          = 10,
    parameter int PROBE_STEP  = 8,
    parameter int NORESP      = 2,
    parameter int PROBE_TRIES = 4,
    parameter int SETTLE_AVGS = 5,
    parameter int DEADBAND    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_req_i,
    input  logic          pre_sel_i,
    input  logic [AW-1:0] target_i,
    input  logic          avg_v_i,
    input  logic [AW-1:0] avg_d_i,
    input  logic          bound_i,
    output logic [DW-1:0] duty_o,
    output logic          clr_o,
    output logic          conv_en_o,
    output logic          pol_o,
    output logic          locked_o,
    output logic          fault_o
);
    localparam logic [DW-1:0] DMAX = '1;
    localparam logic [DW-1:0] DMID = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] STEP = DW'(PROBE_STEP);
    localparam logic [DW-1:0] HEAD = DMAX - STEP;
    localparam int RW = $clog2(PROBE_TRIES);
    localparam int CW = $clog2(SETTLE_AVGS);
    localparam int EW = AW + 2;
    localparam logic signed [EW-1:0] NR = EW'(NORESP);
    localparam logic signed [EW-1:0] DB = EW'(DEADBAND);

    ctrl_state_e st_q;
    logic [DW-1:0] duty_q;
    logic [AW-1:0] base_q;
    logic [RW-1:0] retry_q;
    logic [CW-1:0] settle_q;
    logic          up_q, learned_q, en_q, pol_q, lock_q, fault_q;

    logic signed [EW-1:0] probe_d, trk_e;
    logic probe_resp, in_band, want_up, settled, retry_last, probe_rose;

    always_comb begin
        probe_d    = $signed({2'b00, avg_d_i}) - $signed({2'b00, base_q});
        trk_e      = $signed({2'b00, avg_d_i}) - $signed({2'b00, target_i});
        probe_resp = (probe_d >= NR) || (probe_d <= -NR);
        probe_rose = !probe_d[EW-1] && (probe_d != '0);
        in_band    = (trk_e >= -DB) && (trk_e <= DB);
        want_up    = ((avg_d_i < target_i) == pol_q);
        settled    = (settle_q == CW'(SETTLE_AVGS - 1));
        retry_last = (retry_q == RW'(PROBE_TRIES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            duty_q    <= '0;
            base_q    <= '0;
            retry_q   <= '0;
            settle_q  <= '0;
            up_q      <= 1'b0;
            learned_q <= 1'b0;
            en_q      <= 1'b0;
            pol_q     <= 1'b0;
            lock_q    <= 1'b0;
            fault_q   <= 1'b0;
        end else if (!en_req_i) begin
            st_q    <= S_IDLE;
            en_q    <= 1'b0;
            lock_q  <= 1'b0;
            fault_q <= 1'b0;
            duty_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    retry_q  <= '0;
                    settle_q <= '0;
                    if (pre_sel_i) begin
                        duty_q <= DMAX;
                        st_q   <= S_PRECHG;
                    end else begin
                        duty_q <= DMID;
                        en_q   <= 1'b1;
                        st_q   <= learned_q ? S_TRACK : S_PBASE;
                    end
                end
                S_PRECHG: begin
                    if (bound_i) st_q <= S_LAUNCH;
                end
                S_LAUNCH: begin
                    en_q <= 1'b1;
                    st_q <= learned_q ? S_TRACK : S_PBASE;
                end
                S_PBASE: begin
                    if (avg_v_i) begin
                        if (settled) begin
                            base_q   <= avg_d_i;
                            settle_q <= '0;
                            st_q     <= S_PWAIT;
                            if (duty_q <= HEAD) begin
                                duty_q <= duty_q + STEP;
                                up_q   <= 1'b1;
                            end else begin
                                duty_q <= duty_q - STEP;
                                up_q   <= 1'b0;
                            end
                        end else begin
                            settle_q <= settle_q + CW'(1);
                        end
                    end
                end
                S_PWAIT: begin
                    if (avg_v_i) begin
                        if (settled) begin
                            settle_q <= '0;
                            if (probe_resp) begin
                                pol_q     <= probe_polarity(probe_rose, up_q);
                                learned_q <= 1'b1;
                                st_q      <= S_TRACK;
                            end else if (retry_last) begin
                                fault_q <= 1'b1;
                                st_q    <= S_FAULT;
                            end else begin
                                retry_q <= retry_q + RW'(1);
                                st_q    <= S_PBASE;
                            end
                        end else begin
                            settle_q <= settle_q + CW'(1);
                        end
                    end
                end
                S_TRACK: begin
                    if (avg_v_i) begin
                        if (in_band) begin
                            lock_q <= 1'b1;
                        end else begin
                            lock_q <= 1'b0;
                            if (want_up ? (duty_q == DMAX) : (duty_q == '0)) begin
                                fault_q <= 1'b1;
                                st_q    <= S_FAULT;
                            end else if (want_up) begin
                                duty_q <= duty_q + DW'(1);
                            end else begin
                                duty_q <= duty_q - DW'(1);
                            end
                        end
                    end
                end
                S_FAULT: begin
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign duty_o    = duty_q;
    assign clr_o     = (st_q == S_IDLE);
    assign conv_en_o = en_q;
    assign pol_o     = pol_q;
    assign locked_o  = lock_q;
    assign fault_o   = fault_q;

    assert_plain_start_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && en_req_i && !pre_sel_i) |=> conv_en_o);
    assert_precharge_holds_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PRECHG) |-> !conv_en_o);
    assert_probe_wait_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PWAIT && en_req_i && !avg_v_i) |=> $stable(duty_q));
    assert_track_steps_on_avg_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TRACK && en_req_i && !avg_v_i) |=> $stable(duty_q));
    assert_lock_only_tracking_R7: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (st_q == S_TRACK));
    assert_fault_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_FAULT && en_req_i) |=> (fault_o && $stable(duty_q)));
    assert_drop_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !en_req_i |=> (!conv_en_o && !locked_o && !fault_o));

endmodule

// File: rtl/closed_loop_trim.sv
module closed_loop_trim
    import trim_pkg::*;
#(
    parameter int DUTY_W      = 10,
    parameter int ADC_W       = 10,
    parameter int AVG_N       = 4,
    parameter int PROBE_STEP  = 8,
    parameter int NORESP      = 2,
    parameter int PROBE_TRIES = 4,
    parameter int SETTLE_AVGS = 5,
    parameter int DEADBAND    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic [ADC_W-1:0] target,
    input  logic             sample_valid,
    input  logic [ADC_W-1:0] sample_data,
    input  logic             precharge_sel,
    output logic             trim_pwm,
    output logic             conv_en,
    output logic             trim_pol,
    output logic             locked,
    output logic             fault
);
    logic              clr;
    logic              avg_v;
    logic [ADC_W-1:0]  avg_d;
    logic [DUTY_W-1:0] duty;
    logic              bound;

    trim_avg #(.AW(ADC_W), .NAVG(AVG_N)) avg_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .smp_v (sample_valid),
        .smp_d (sample_data),
        .avg_v (avg_v),
        .avg_d (avg_d)
    );

    trim_ctrl #(
        .DW          (DUTY_W),
        .AW          (ADC_W),
        .PROBE_STEP  (PROBE_STEP),
        .NORESP      (NORESP),
        .PROBE_TRIES (PROBE_TRIES),
        .SETTLE_AVGS (SETTLE_AVGS),
        .DEADBAND    (DEADBAND)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .en_req_i  (en_req),
        .pre_sel_i (precharge_sel),
        .target_i  (target),
        .avg_v_i   (avg_v),
        .avg_d_i   (avg_d),
        .bound_i   (bound),
        .duty_o    (duty),
        .clr_o     (clr),
        .conv_en_o (conv_en),
        .pol_o     (trim_pol),
        .locked_o  (locked),
        .fault_o   (fault)
    );

    trim_pwm #(.DW(DUTY_W)) pwm_i (
        .clk     (clk),
        .rst     (rst),
        .duty_i  (duty),
        .pwm_o   (trim_pwm),
        .bound_o (bound)
    );

endmodule

// File: tb/closed_loop_trim_tb_top.sv
module closed_loop_trim_tb_top;
    localparam int ST_IDLE = 0, ST_PRE = 1, ST_LAUNCH = 2, ST_BASE = 3,
                   ST_WAIT = 4, ST_TRACK = 5, ST_FAULT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_req = 1'b0;
    logic       pre_sel = 1'b0;
    logic       smp_v = 1'b0;
    logic [9:0] target = '0;
    logic [9:0] smp_d = '0;
    logic       pwm, cen, pol, lck, flt;

    always #2 clk = ~clk;

    closed_loop_trim dut_i (
        .clk           (clk),
        .rst           (rst),
        .en_req        (en_req),
        .target        (target),
        .sample_valid  (smp_v),
        .sample_data   (smp_d),
        .precharge_sel (pre_sel),
        .trim_pwm      (pwm),
        .conv_en       (cen),
        .trim_pol      (pol),
        .locked        (lck),
        .fault         (flt)
    );

    int nvec = 0, nbad = 0, cyc = 0, tick = 0, plant_mode = 0;
    bit done = 0;

    // Reference model state
    int m_cnt = 0, m_app = 0, m_duty = 0, m_st = 0, m_en = 0, m_pol = 0, m_learn = 0;
    int m_lock = 0, m_fault = 0, m_base = 0, m_retry = 0, m_settle = 0, m_up = 0;
    int m_avg = 0, m_avgv = 0;
    int win[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int plant_v();
        if (m_en == 0) return 0;
        case (plant_mode)
            0:       return 200 + m_duty / 2;
            1:       return 900 - m_duty / 2;
            default: return 500;
        endcase
    endfunction

    // Cycle model
    always @(posedge clk) begin
        int o_avg, o_avgv, o_cnt, o_st, d, e;
        bit up;
        if (rst) begin
            m_cnt = 0; m_app = 0; m_duty = 0; m_st = ST_IDLE; m_en = 0; m_pol = 0;
            m_learn = 0; m_lock = 0; m_fault = 0; m_base = 0; m_retry = 0;
            m_settle = 0; m_up = 0; m_avg = 0; m_avgv = 0;
            win.delete();
        end else begin
            o_avg = m_avg; o_avgv = m_avgv; o_cnt = m_cnt; o_st = m_st;
            // PWM: R2
            if (m_cnt == 1023) m_app = m_duty;
            m_cnt = (m_cnt + 1) % 1024;
            // Averager: R1
            if (o_st == ST_IDLE) begin
                win.delete();
                m_avgv = 0;
            end else if (smp_v) begin
                win.push_front(int'(smp_d));
                if (win.size() > 4) void'(win.pop_back());
                m_avgv = (win.size() == 4) ? 1 : 0;
                if (m_avgv == 1) m_avg = (win[0] + win[1] + win[2] + win[3]) / 4;
            end else begin
                m_avgv = 0;
            end
            // Controller: R3 to R9
            if (!en_req) begin
                m_st = ST_IDLE; m_en = 0; m_lock = 0; m_fault = 0; m_duty = 0;
            end else begin
                case (o_st)
                    ST_IDLE: begin
                        m_retry = 0; m_settle = 0;
                        if (pre_sel) begin
                            m_duty = 1023; m_st = ST_PRE;
                        end else begin
                            m_duty = 512; m_en = 1;
                            m_st = (m_learn != 0) ? ST_TRACK : ST_BASE;
                        end
                    end
                    ST_PRE: if (o_cnt == 1023) m_st = ST_LAUNCH;
                    ST_LAUNCH: begin
                        m_en = 1;
                        m_st = (m_learn != 0) ? ST_TRACK : ST_BASE;
                    end
                    ST_BASE: if (o_avgv != 0) begin
                        if (m_settle == 4) begin
                            m_base = o_avg; m_settle = 0; m_st = ST_WAIT;
                            if (m_duty <= 1015) begin m_duty += 8; m_up = 1; end
                            else begin m_duty -= 8; m_up = 0; end
                        end else m_settle++;
                    end
                    ST_WAIT: if (o_avgv != 0) begin
                        if (m_settle == 4) begin
                            d = o_avg - m_base; m_settle = 0;
                            if (d >= 2 || d <= -2) begin
                                m_pol = ((d > 0) == (m_up == 1)) ? 1 : 0;
                                m_learn = 1; m_st = ST_TRACK;
                            end else if (m_retry == 3) begin
                                m_fault = 1; m_st = ST_FAULT;
                            end else begin
                                m_retry++; m_st = ST_BASE;
                            end
                        end else m_settle++;
                    end
                    ST_TRACK: if (o_avgv != 0) begin
                        e = o_avg - int'(target);
                        if (e >= -1 && e <= 1) m_lock = 1;
                        else begin
                            m_lock = 0;
                            up = ((o_avg < int'(target)) == (m_pol == 1));
                            if (up ? (m_duty == 1023) : (m_duty == 0)) begin
                                m_fault = 1; m_st = ST_FAULT;
                            end else if (up) m_duty++;
                            else m_duty--;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ADC sample source, every eighth cycle
    always @(negedge clk) begin
        if (rst) begin
            smp_v = 1'b0;
            tick = 0;
        end else begin
            tick++;
            smp_v = (tick % 8 == 0);
            smp_d = 10'(plant_v());
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2", "trim_pwm", int'(pwm), (m_cnt < m_app) ? 1 : 0);
            chk("R3 R4 R9", "conv_en", int'(cen), m_en);
            chk("R5", "trim_pol", int'(pol), m_pol);
            chk("R1 R6 R7", "locked", int'(lck), m_lock);
            chk("R8", "fault", int'(flt), m_fault);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1;
            nbad++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic do_reset();
        en_req = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "pol after reset", int'(pol), 0);
        chk("R10", "pwm after reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R10", "conv_en in reset", int'(cen), 0);
        chk("R10", "locked in reset", int'(lck), 0);
        chk("R10", "fault in reset", int'(flt), 0);
        chk("R10", "pwm in reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);

        // Rising plant, plain start
        plant_mode = 0; target = 10'd480; pre_sel = 1'b0; en_req = 1'b1;
        @(negedge clk);
        chk("R3", "conv_en one cycle after request", int'(cen), 1);
        repeat (3000) @(negedge clk);
        chk("R5", "learned polarity rising plant", int'(pol), 1);
        chk("R7", "locked at 480", int'(lck), 1);
        chk("R8", "no fault", int'(flt), 0);

        // Drop request
        en_req = 1'b0;
        @(negedge clk);
        chk("R9", "conv_en after drop", int'(cen), 0);
        chk("R9", "locked after drop", int'(lck), 0);
        chk("R9", "polarity kept after drop", int'(pol), 1);
        repeat (20) @(negedge clk);

        // Unreachable target with learned polarity
        target = 10'd1000; en_req = 1'b1;
        repeat (6000) @(negedge clk);
        chk("R8", "fault at duty limit", int'(flt), 1);
        chk("R8", "not locked in fault", int'(lck), 0);
        chk("R8", "enable held in fault", int'(cen), 1);

        // Falling plant with precharge
        do_reset();
        plant_mode = 1; pre_sel = 1'b1; target = 10'd600; en_req = 1'b1;
        @(negedge clk);
        chk("R4", "enable held during precharge", int'(cen), 0);
        repeat (6000) @(negedge clk);
        chk("R5", "learned polarity falling plant", int'(pol), 0);
        chk("R7", "locked at 600", int'(lck), 1);
        chk("R4", "enabled after precharge", int'(cen), 1);

        // Flat plant, probe never responds
        do_reset();
        plant_mode = 2; pre_sel = 1'b0; target = 10'd500; en_req = 1'b1;
        repeat (1500) @(negedge clk);
        chk("R5", "fault after four silent probes", int'(flt), 1);
        chk("R5", "polarity not learned", int'(pol), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule